// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block collects interrupt requests from eight input lines and presents one interrupt output to a processor. Each line can be set to trigger on a rising edge or on a high level. Pending requests go into a request register. A mask register keeps individual lines from reaching the processor but does not remove their pending requests. A priority resolver selects the lowest-numbered pending, unmasked line. That line wins only if it outranks every level already in service. While a winner exists and no acknowledge is in progress, the registered interrupt output is high.

The processor answers with a two-cycle acknowledge. In the first cycle the controller freezes its choice and drops the interrupt output. In the second cycle it commits the choice: the chosen request moves into the in-service register and an 8-bit vector is returned with a one-cycle valid strobe. If the chosen request has disappeared before the commit, the controller returns the vector for the lowest level (7) and sets no in-service bit.

Software drives the block through a write-strobe command port. The commands are:
- a non-specific end-of-interrupt, which retires the highest-priority level in service;
- a mask write;
- a per-line trigger mode write;
- a write of the 5-bit vector base.

Top module: `prio_intc`

## Requirements
- R1: After reset, int_o, vec_valid_o and vector_o are 0. All lines are unmasked and in edge mode, the vector base is 0, and nothing is pending or in service.
- R2: In edge mode (mode bit 0), a line that goes from low to high produces exactly one request. A line held high produces no further request until it has been seen low again.
- R3: In level mode (mode bit 1), a line requests while it is high and stops requesting the cycle after it goes low. A line still high after its end-of-interrupt raises int_o again.
- R4: int_o is high in the cycle after one where an unmasked request outranks all in-service levels and no acknowledge was sampled or frozen. It is low during the frozen acknowledge cycle.
- R5: A set mask bit keeps its line from raising int_o but keeps the request pending. Clearing the mask bit later lets the request raise int_o.
- R6: inta_i sampled high while idle freezes the winner. On the next clock the controller clears that request, sets its in-service bit, and drives vector_o = {base, level} with vec_valid_o high for exactly one cycle.
- R7: Among pending unmasked requests, the lowest line number has the highest priority. Level 0 is highest and level 7 is lowest.
- R8: While a level is in service, requests of the same or lower priority do not raise int_o. Requests of higher priority still do.
- R9: An end-of-interrupt command clears the lowest-numbered set in-service bit. A pending request that becomes eligible then raises int_o on the next cycle.
- R10: If the frozen request is no longer pending at commit, or no request was pending at freeze, vector_o = {base, 3'd7} and no in-service bit is set.
- R11: Commands are written when cmd_we_i is high. cmd_sel_i selects the command: 0 is end-of-interrupt, 1 writes the mask from cmd_data_i[7:0], 2 writes the mode from cmd_data_i[7:0], and 3 writes the base from cmd_data_i[7:3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ir_i | input | 8 | Interrupt request lines, bit index equals level |
| inta_i | input | 1 | Acknowledge strobe from processor |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_sel_i | input | 2 | Command select |
| cmd_data_i | input | 8 | Command data |
| int_o | output | 1 | Interrupt request to processor |
| vector_o | output | 8 | Vector returned by acknowledge |
| vec_valid_o | output | 1 | One-cycle strobe marking a new vector |

## Verification
On every cycle, assertions check the following:
- int_o is low while an acknowledge is frozen, and it is only raised after some unmasked request existed.
- A held-high edge line never re-requests, and a low level line stops requesting.
- The in-service set grows by at most one bit per cycle, and a committed level outranks all levels already in service.
- An end-of-interrupt removes exactly one in-service bit, and a default-vector acknowledge leaves the in-service set unchanged.

Only the bench scenarios can show the following:
- the actual vector values;
- priority order between simultaneous requests;
- mask release;
- the re-raise after end-of-interrupt;
- the fact that a default acknowledge leaves level 7 free to be served later.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  typedef enum logic [1:0] {
    CMD_EOI  = 2'd0,
    CMD_MASK = 2'd1,
    CMD_MODE = 2'd2,
    CMD_BASE = 2'd3
  } cmd_e;
endpackage

// File: rtl/prio_intc_req.sv
module prio_intc_req #(
  parameter int N_LINES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] ir_i,
  input  logic [N_LINES-1:0] lvl_mode_i,
  input  logic [N_LINES-1:0] clr_i,
  output logic [N_LINES-1:0] irr_o
);
  logic [N_LINES-1:0] arm_q, irr_q;

  // edge lines need a pending request or a fresh arm; level lines follow the pin
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= '0;
      irr_q <= '0;
    end else begin
      arm_q <= ~ir_i;
      irr_q <= ir_i & (lvl_mode_i | irr_q | arm_q) & ~clr_i;
    end
  end

  assign irr_o = irr_q;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    AST_EDGE_NO_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lvl_mode_i[i] && $past(ir_i[i]) && ir_i[i] && !irr_q[i]) |=> !irr_q[i]); // R2
    AST_LEVEL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lvl_mode_i[i] && !ir_i[i]) |=> !irr_q[i]); // R3
  end
endmodule

// File: rtl/prio_intc_resolve.sv
module prio_intc_resolve #(
  parameter int N_LINES = 8,
  localparam int LVL_W = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] irr_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic [N_LINES-1:0] isr_i,
  output logic               win_valid_o,
  output logic [LVL_W-1:0]   win_lvl_o
);
  logic [N_LINES-1:0] elig;
  int unsigned ceil_lvl;

  assign elig = irr_i & ~mask_i;

  always_comb begin
    ceil_lvl    = N_LINES;
    win_valid_o = 1'b0;
    win_lvl_o   = '0;
    for (int i = N_LINES - 1; i >= 0; i--)
      if (isr_i[i]) ceil_lvl = i;
    for (int i = N_LINES - 1; i >= 0; i--)
      if (elig[i] && (i < ceil_lvl)) begin
        win_valid_o = 1'b1;
        win_lvl_o   = LVL_W'(i);
      end
  end
endmodule

// File: rtl/prio_intc_ack.sv
module prio_intc_ack #(
  parameter int N_LINES = 8,
  parameter int VEC_W   = 8,
  localparam int LVL_W  = $clog2(N_LINES),
  localparam int BASE_W = VEC_W - LVL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               inta_i,
  input  logic               eoi_i,
  input  logic               win_valid_i,
  input  logic [LVL_W-1:0]   win_lvl_i,
  input  logic [N_LINES-1:0] irr_i,
  input  logic [BASE_W-1:0]  base_i,
  output logic [N_LINES-1:0] clr_o,
  output logic [N_LINES-1:0] isr_o,
  output logic               frozen_o,
  output logic [VEC_W-1:0]   vector_o,
  output logic               vec_valid_o
);
  logic               frozen_q, fz_valid_q;
  logic [LVL_W-1:0]   fz_lvl_q;
  logic [N_LINES-1:0] isr_q, set_vec, eoi_clr;
  logic [VEC_W-1:0]   vec_q;
  logic               vv_q, hit;

  // commit only if the frozen request still stands
  assign hit     = frozen_q & fz_valid_q & irr_i[fz_lvl_q];
  assign set_vec = hit ? (N_LINES'(1) << fz_lvl_q) : '0;
  assign eoi_clr = eoi_i ? (isr_q & (~isr_q + N_LINES'(1))) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frozen_q   <= 1'b0;
      fz_valid_q <= 1'b0;
      fz_lvl_q   <= '0;
      isr_q      <= '0;
      vec_q      <= '0;
      vv_q       <= 1'b0;
    end else begin
      frozen_q <= !frozen_q && inta_i;
      if (!frozen_q && inta_i) begin
        fz_valid_q <= win_valid_i;
        fz_lvl_q   <= win_lvl_i;
      end
      isr_q <= (isr_q & ~eoi_clr) | set_vec;
      vv_q  <= frozen_q;
      if (frozen_q) vec_q <= {base_i, hit ? fz_lvl_q : {LVL_W{1'b1}}};
    end
  end

  assign clr_o       = set_vec;
  assign isr_o       = isr_q;
  assign frozen_o    = frozen_q;
  assign vector_o    = vec_q;
  assign vec_valid_o = vv_q;

  AST_VEC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vv_q |=> !vv_q); // R6
  AST_ISR_GROW_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(isr_q) <= $countones($past(isr_q)) + 1); // R6
  AST_NEST_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> ((isr_q & ~({N_LINES{1'b1}} << (int'(fz_lvl_q) + 1))) == '0)); // R8
  AST_EOI_RETIRES_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && isr_q != '0 && !hit) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1)); // R9
  AST_DEFAULT_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_q && !hit) |=> ((isr_q & ~$past(isr_q)) == '0)); // R10
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int VEC_W   = 8,
  localparam int LVL_W  = $clog2(N_LINES),
  localparam int BASE_W = VEC_W - LVL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] ir_i,
  input  logic               inta_i,
  input  logic               cmd_we_i,
  input  logic [1:0]         cmd_sel_i,
  input  logic [VEC_W-1:0]   cmd_data_i,
  output logic               int_o,
  output logic [VEC_W-1:0]   vector_o,
  output logic               vec_valid_o
);
  logic [N_LINES-1:0] mask_q, mode_q, irr, isr, clr;
  logic [BASE_W-1:0]  base_q;
  logic               win_valid, frozen, int_q, eoi;
  logic [LVL_W-1:0]   win_lvl;

  assign eoi = cmd_we_i && (cmd_e'(cmd_sel_i) == CMD_EOI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      mode_q <= '0;
      base_q <= '0;
    end else if (cmd_we_i) begin
      unique case (cmd_e'(cmd_sel_i))
        CMD_MASK: mask_q <= cmd_data_i[N_LINES-1:0];
        CMD_MODE: mode_q <= cmd_data_i[N_LINES-1:0];
        CMD_BASE: base_q <= cmd_data_i[VEC_W-1:LVL_W];
        default:  ;
      endcase
    end
  end

  prio_intc_req #(.N_LINES(N_LINES)) u_req (
    .clk_i(clk_i), .rst_ni(rst_ni), .ir_i(ir_i),
    .lvl_mode_i(mode_q), .clr_i(clr), .irr_o(irr)
  );

  prio_intc_resolve #(.N_LINES(N_LINES)) u_res (
    .irr_i(irr), .mask_i(mask_q), .isr_i(isr),
    .win_valid_o(win_valid), .win_lvl_o(win_lvl)
  );

  prio_intc_ack #(.N_LINES(N_LINES), .VEC_W(VEC_W)) u_ack (
    .clk_i(clk_i), .rst_ni(rst_ni), .inta_i(inta_i), .eoi_i(eoi),
    .win_valid_i(win_valid), .win_lvl_i(win_lvl), .irr_i(irr), .base_i(base_q),
    .clr_o(clr), .isr_o(isr), .frozen_o(frozen),
    .vector_o(vector_o), .vec_valid_o(vec_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) int_q <= 1'b0;
    else         int_q <= win_valid && !frozen && !inta_i;
  end

  assign int_o = int_q;

  AST_INT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_q |-> $past((irr & ~mask_q) != '0)); // R5
  AST_INT_LOW_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen |-> !int_q); // R4
endmodule

// File: tb/prio_intc_test.sv
`timescale 1ns/1ps
module prio_intc_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] ir_i = '0;
  logic       inta_i = 1'b0;
  logic       cmd_we_i = 1'b0;
  logic [1:0] cmd_sel_i = '0;
  logic [7:0] cmd_data_i = '0;
  logic       int_o, vec_valid_o;
  logic [7:0] vector_o;
  int checks = 0, fails = 0;

  always #4 clk_i = ~clk_i;

  prio_intc uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ir_i(ir_i), .inta_i(inta_i),
    .cmd_we_i(cmd_we_i), .cmd_sel_i(cmd_sel_i), .cmd_data_i(cmd_data_i),
    .int_o(int_o), .vector_o(vector_o), .vec_valid_o(vec_valid_o)
  );

  // behavioural reference, stepped on each rising edge
  logic [7:0] m_irr, m_arm, m_isr, m_mask, m_mode, m_vec, n_irr, n_isr, m_set;
  logic [4:0] m_base;
  logic       m_ph, m_fv, m_int, m_vv, m_hit;
  int         m_fl, ceil_l, win;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_irr = 0; m_arm = 0; m_isr = 0; m_mask = 0; m_mode = 0; m_vec = 0;
      m_base = 0; m_ph = 0; m_fv = 0; m_int = 0; m_vv = 0; m_fl = 0;
    end else begin
      ceil_l = 8; win = -1;
      for (int i = 7; i >= 0; i--) if (m_isr[i]) ceil_l = i;
      for (int i = 7; i >= 0; i--) if (m_irr[i] && !m_mask[i] && i < ceil_l) win = i;
      m_set = 0; n_isr = m_isr;
      if (m_ph) begin
        m_hit = m_fv && m_irr[m_fl];
        if (m_hit) m_set[m_fl] = 1'b1;
        m_vec = {m_base, m_hit ? 3'(m_fl) : 3'd7};
        m_vv = 1'b1;
      end else m_vv = 1'b0;
      if (cmd_we_i && cmd_sel_i == 2'd0)
        for (int i = 0; i < 8; i++) if (n_isr[i]) begin n_isr[i] = 1'b0; break; end
      n_isr = n_isr | m_set;
      for (int i = 0; i < 8; i++)
        n_irr[i] = ir_i[i] && (m_mode[i] || m_irr[i] || m_arm[i]) && !m_set[i];
      m_arm = ~ir_i;
      m_int = (win >= 0) && !m_ph && !inta_i;
      if (!m_ph && inta_i) begin
        m_ph = 1'b1; m_fv = (win >= 0); m_fl = (win >= 0) ? win : 0;
      end else m_ph = 1'b0;
      m_isr = n_isr; m_irr = n_irr;
      if (cmd_we_i && cmd_sel_i == 2'd1) m_mask = cmd_data_i;
      if (cmd_we_i && cmd_sel_i == 2'd2) m_mode = cmd_data_i;
      if (cmd_we_i && cmd_sel_i == 2'd3) m_base = cmd_data_i[7:3];
    end
  end

  always @(negedge clk_i) if (rst_ni) begin
    checks++;
    if (int_o !== m_int) begin fails++; $display("FAIL R4 int_o act=%b exp=%b", int_o, m_int); end
    checks++;
    if (vec_valid_o !== m_vv || vector_o !== m_vec) begin
      fails++;
      $display("FAIL R6 vec act=%b/%h exp=%b/%h", vec_valid_o, vector_o, m_vv, m_vec);
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin fails++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic cmd(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk_i); cmd_we_i = 1'b1; cmd_sel_i = sel; cmd_data_i = data;
    @(negedge clk_i); cmd_we_i = 1'b0;
  endtask

  task automatic ack(input string tag, input logic [7:0] exp);
    @(negedge clk_i); inta_i = 1'b1;
    @(negedge clk_i); inta_i = 1'b0;
    chk({tag, " int low frozen"}, {7'd0, int_o}, 8'd0);
    @(negedge clk_i);
    chk({tag, " valid"}, {7'd0, vec_valid_o}, 8'd1);
    chk({tag, " vector"}, vector_o, exp);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_n(3); rst_ni = 1'b1; wait_n(2);
    chk("R1 int", {7'd0, int_o}, 8'd0);
    chk("R1 valid", {7'd0, vec_valid_o}, 8'd0);
    chk("R1 vector", vector_o, 8'h00);

    cmd(2'd3, 8'h40); // R11 base
    ir_i[3] = 1'b1; wait_n(3);
    chk("R2 edge raises int", {7'd0, int_o}, 8'd1);
    ack("R6 ack3", 8'h43);
    wait_n(2); chk("R8 same level held off", {7'd0, int_o}, 8'd0);
    cmd(2'd0, 8'h00); wait_n(3);
    chk("R2 held high no repeat", {7'd0, int_o}, 8'd0);
    ir_i = 8'h00; wait_n(2);

    ir_i = 8'h22; wait_n(3);
    ack("R7 priority", 8'h41);
    wait_n(2); chk("R8 lower held off", {7'd0, int_o}, 8'd0);
    cmd(2'd0, 8'h00); wait_n(1);
    chk("R9 eoi re-raise", {7'd0, int_o}, 8'd1);
    ack("R9 ack5", 8'h45);
    ir_i = 8'h04; wait_n(3);
    chk("R8 higher nests", {7'd0, int_o}, 8'd1);
    ack("R8 ack2", 8'h42);
    cmd(2'd0, 8'h00); cmd(2'd0, 8'h00); ir_i = 8'h00; wait_n(3);
    chk("R9 all retired idle", {7'd0, int_o}, 8'd0);

    cmd(2'd1, 8'h10); // R11 mask
    ir_i[4] = 1'b1; wait_n(4);
    chk("R5 masked no int", {7'd0, int_o}, 8'd0);
    cmd(2'd1, 8'h00); wait_n(2);
    chk("R5 unmask raises", {7'd0, int_o}, 8'd1);
    ack("R5 ack4", 8'h44);
    cmd(2'd0, 8'h00); ir_i = 8'h00; wait_n(2);

    cmd(2'd2, 8'h40); // R11 mode
    ir_i[6] = 1'b1; wait_n(3);
    ack("R3 level ack", 8'h46);
    cmd(2'd0, 8'h00); wait_n(1);
    chk("R3 level re-raise", {7'd0, int_o}, 8'd1);
    ack("R3 level ack again", 8'h46);
    cmd(2'd0, 8'h00); ir_i[6] = 1'b0; wait_n(3);
    chk("R3 level dropped", {7'd0, int_o}, 8'd0);

    ir_i[6] = 1'b1; wait_n(3); ir_i[6] = 1'b0; wait_n(1);
    ack("R10 level vanished", 8'h47);
    ir_i[0] = 1'b1; wait_n(1); ir_i[0] = 1'b0; wait_n(2);
    ack("R10 edge vanished", 8'h47);
    ir_i[7] = 1'b1; wait_n(3);
    chk("R10 no isr7 left", {7'd0, int_o}, 8'd1);
    ack("R10 real7", 8'h47);
    cmd(2'd0, 8'h00); ir_i = 8'h00; wait_n(4);
    chk("R1 idle end", {7'd0, int_o}, 8'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule